// File: doc/BRIEF.md
# Multi-Channel Hiccup Recovery Sequencer

This controller sits between the overcurrent detectors of several buck channels and the rail enables. When a channel asks for hiccup, a per-channel policy bit picks the response. With the bit at 0 the whole supply goes down: every buck enable drops, a global shutdown line (which also turns off the linear regulators) rises, and the reset output is pulled low. After a fixed number of millisecond ticks, everything comes back with a soft-start kick on every channel. With the bit at 1 only the faulting channel is parked for three times its own soft-start duration, while the rest keep running. At the end of that off-time it is re-enabled with a soft-start kick.

The reset output is released only after every channel that belongs to the power-up sequence is running and reports power-good. It must then stay that way for a programmed number of ticks. Each hiccup is latched per channel in a sticky overcurrent flag. Unmasked channels also pull the interrupt output low. A per-channel write-one-to-clear strobe clears both the flag and the pending interrupt.

Top module: `hiccup_recovery_seq`

## Requirements
- R1: After reset all `ch_en` bits are 1, `all_off` is 0, `rst_out_n` and `irq_out_n` are 1, and `oc_flag` and `ss_start` are 0.
- R2: A request on a channel whose `iso_mode` bit is 0 (global policy) makes `all_off` 1, all `ch_en` bits 0 and `rst_out_n` 0 on the next cycle.
- R3: In global policy, `all_off` returns to 0 on the GLOBAL_MS-th `ms_tick` after the request. In that same cycle every `ch_en` bit returns to 1 and every `ss_start` bit is 1 for exactly one cycle.
- R4: A request on a channel whose `iso_mode` bit is 1 clears only that channel's `ch_en` bit on the next cycle. Other channels' enables are unchanged.
- R5: In per-channel policy `rst_out_n` goes to 0 only if the faulting channel's `in_seq` bit is 1.
- R6: `irq_out_n` goes to 0 on a hiccup only for a channel whose `irq_mask` bit is 0. It stays 0 until that channel's `oc_clr` bit is pulsed.
- R7: A channel in per-channel off-time re-enables on the (3 x `ss_len`)-th tick after its request. In that cycle its `ss_start` bit is 1 for one cycle.
- R8: `rst_out_n` returns to 1 only after `rst_dly` consecutive ticks during which `all_off` is 0, no `in_seq` channel is in off-time, and `pok` is 1 on every `in_seq` channel. A tick that does not meet these conditions restarts the count.
- R9: `oc_flag[i]` is set by an accepted hiccup request on channel i. It stays set until `oc_clr[i]` is pulsed.
- R10: If several channels request in the same cycle and any of them has `iso_mode` 0, the global policy is taken.
- R11: A new request on a channel already in its off-time restarts that channel's off-time count from zero.
- R12: Requests that arrive while `all_off` is 1 are ignored. They set no flag and start no per-channel off-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| hic_req | input | N_CH | Hiccup request per channel |
| pok | input | N_CH | Power-good per channel |
| iso_mode | input | N_CH | Policy per channel: 1 isolate, 0 global |
| in_seq | input | N_CH | Channel belongs to the power-up sequence |
| irq_mask | input | N_CH | 1 suppresses the interrupt for that channel |
| ss_len | input | N_CH*SS_W | Soft-start duration per channel in ticks, channel i at bits [i*SS_W +: SS_W] |
| rst_dly | input | DLY_W | Reset release delay in ticks |
| oc_clr | input | N_CH | Write-one-to-clear for flag and pending interrupt |
| ch_en | output | N_CH | Buck enable per channel |
| ss_start | output | N_CH | One-cycle soft-start kick per channel |
| all_off | output | 1 | Global shutdown of all rails including LDOs |
| rst_out_n | output | 1 | Active-low system reset |
| irq_out_n | output | 1 | Active-low interrupt |
| oc_flag | output | N_CH | Sticky overcurrent flag per channel |

## Verification
The bench counts the exact tick on which each timer expires. An off-by-one in the off-time, global delay or reset delay shows up as an enable or reset edge one tick early or late. It retriggers a channel in the middle of its off-time. A design that ignores the retrigger would re-enable the channel ten ticks early. It mixes global and isolate requests in one cycle, where a design with the wrong priority leaves the global-policy rails running. It also fires a request during the global shutdown, which a careless design would latch or later act on by parking that channel after restart. The reset release is tested with power-good held low after recovery, which exposes a design that times the release from the enable edge.

// File: rtl/hic_seq_pkg.sv
package hic_seq_pkg;

    // off-time multiple applied to a channel's soft-start duration
    localparam int OFF_MULT = 3;

    typedef enum logic {
        CH_RUN  = 1'b0,
        CH_HOLD = 1'b1
    } ch_state_e;

    typedef enum logic {
        G_RUN  = 1'b0,
        G_DOWN = 1'b1
    } glob_state_e;

    typedef struct packed {
        logic down;     // global shutdown active
        logic restart;  // one-cycle restart strobe
    } gstat_t;

    // next count value and expiry test, one place for every timer
    function automatic logic expired(input logic [31:0] cnt, input logic [31:0] lim);
        return (cnt + 32'd1) >= lim;
    endfunction

endpackage

// File: rtl/hic_global_ctl.sv
module hic_global_ctl
    import hic_seq_pkg::*;
#(
    parameter int GLOBAL_MS = 100
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   trig,
    output gstat_t stat
);
    localparam int GW = $clog2(GLOBAL_MS + 1);

    glob_state_e   st;
    logic [GW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= G_RUN;
            cnt          <= '0;
            stat.restart <= 1'b0;
        end else begin
            stat.restart <= 1'b0;
            if (st == G_RUN) begin
                if (trig) begin
                    st  <= G_DOWN;
                    cnt <= '0;
                end
            end else if (tick) begin
                if (expired(32'(cnt), 32'(GLOBAL_MS))) begin
                    st           <= G_RUN;
                    stat.restart <= 1'b1;
                end else begin
                    cnt <= cnt + GW'(1);
                end
            end
        end
    end

    assign stat.down = (st == G_DOWN);

endmodule

// File: rtl/hic_chan_timer.sv
module hic_chan_timer
    import hic_seq_pkg::*;
#(
    parameter int SS_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            clear,
    input  logic            trig,
    input  logic [SS_W-1:0] ss_len,
    output logic            off,
    output logic            ss_pulse
);
    localparam int CW = SS_W + 2;

    ch_state_e     st;
    logic [CW-1:0] cnt;
    logic [CW-1:0] target;

    assign target = CW'(ss_len) * CW'(OFF_MULT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= CH_RUN;
            cnt      <= '0;
            ss_pulse <= 1'b0;
        end else begin
            ss_pulse <= 1'b0;
            if (clear) begin
                st  <= CH_RUN;
                cnt <= '0;
            end else if (trig) begin
                st  <= CH_HOLD;
                cnt <= '0;
            end else if (st == CH_HOLD && tick) begin
                if (expired(32'(cnt), 32'(target))) begin
                    st       <= CH_RUN;
                    ss_pulse <= 1'b1;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    assign off = (st == CH_HOLD);

endmodule

// File: rtl/hic_rst_release.sv
module hic_rst_release
    import hic_seq_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             hold,
    input  logic             ok,
    input  logic [DLY_W-1:0] dly,
    output logic             rst_n_o
);
    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_n_o <= 1'b1;
            cnt     <= '0;
        end else if (hold) begin
            rst_n_o <= 1'b0;
            cnt     <= '0;
        end else if (!rst_n_o) begin
            if (!ok) begin
                cnt <= '0;
            end else if (tick) begin
                if (expired(32'(cnt), 32'(dly))) begin
                    rst_n_o <= 1'b1;
                end else begin
                    cnt <= cnt + DLY_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/hiccup_recovery_seq.sv
module hiccup_recovery_seq
    import hic_seq_pkg::*;
#(
    parameter int N_CH      = 4,
    parameter int SS_W      = 8,
    parameter int GLOBAL_MS = 100,
    parameter int DLY_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ms_tick,
    input  logic [N_CH-1:0]      hic_req,
    input  logic [N_CH-1:0]      pok,
    input  logic [N_CH-1:0]      iso_mode,
    input  logic [N_CH-1:0]      in_seq,
    input  logic [N_CH-1:0]      irq_mask,
    input  logic [N_CH*SS_W-1:0] ss_len,
    input  logic [DLY_W-1:0]     rst_dly,
    input  logic [N_CH-1:0]      oc_clr,
    output logic [N_CH-1:0]      ch_en,
    output logic [N_CH-1:0]      ss_start,
    output logic                 all_off,
    output logic                 rst_out_n,
    output logic                 irq_out_n,
    output logic [N_CH-1:0]      oc_flag
);
    gstat_t          gs;
    logic            glob_evt;
    logic [N_CH-1:0] iso_evt;
    logic [N_CH-1:0] hit;
    logic [N_CH-1:0] off;
    logic [N_CH-1:0] ch_ss;
    logic [N_CH-1:0] irq_pend;
    logic            seq_ok;

    // any global-policy request wins over isolate requests in the same cycle
    assign glob_evt = (|(hic_req & ~iso_mode)) & ~gs.down;
    assign iso_evt  = (glob_evt | gs.down) ? '0 : (hic_req & iso_mode);
    assign hit      = glob_evt ? hic_req : iso_evt;

    hic_global_ctl #(.GLOBAL_MS(GLOBAL_MS)) u_glob (
        .clk  (clk),
        .rst  (rst),
        .tick (ms_tick),
        .trig (glob_evt),
        .stat (gs)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        hic_chan_timer #(.SS_W(SS_W)) u_tmr (
            .clk      (clk),
            .rst      (rst),
            .tick     (ms_tick),
            .clear    (glob_evt | gs.down),
            .trig     (iso_evt[g]),
            .ss_len   (ss_len[g*SS_W +: SS_W]),
            .off      (off[g]),
            .ss_pulse (ch_ss[g])
        );
    end

    assign ch_en    = gs.down ? '0 : ~off;
    assign all_off  = gs.down;
    assign ss_start = ch_ss | {N_CH{gs.restart}};

    assign seq_ok = ~gs.down & ~(|(off & in_seq)) & (&(pok | ~in_seq));

    hic_rst_release #(.DLY_W(DLY_W)) u_rel (
        .clk     (clk),
        .rst     (rst),
        .tick    (ms_tick),
        .hold    (glob_evt | (|(iso_evt & in_seq))),
        .ok      (seq_ok),
        .dly     (rst_dly),
        .rst_n_o (rst_out_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            oc_flag  <= '0;
            irq_pend <= '0;
        end else begin
            oc_flag  <= (oc_flag & ~oc_clr) | hit;
            irq_pend <= (irq_pend & ~oc_clr) | (hit & ~irq_mask);
        end
    end

    assign irq_out_n = ~(|irq_pend);

endmodule

// File: rtl/hiccup_recovery_seq_chk.sv
module hiccup_recovery_seq_chk #(
    parameter int N_CH = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            ms_tick,
    input logic [N_CH-1:0] hic_req,
    input logic [N_CH-1:0] pok,
    input logic [N_CH-1:0] iso_mode,
    input logic [N_CH-1:0] in_seq,
    input logic [N_CH-1:0] irq_mask,
    input logic [N_CH-1:0] oc_clr,
    input logic [N_CH-1:0] ch_en,
    input logic [N_CH-1:0] ss_start,
    input logic            all_off,
    input logic            rst_out_n,
    input logic            irq_out_n,
    input logic [N_CH-1:0] oc_flag
);
    // R2
    glob_down_chk: assert property (@(posedge clk) disable iff (rst)
        ((|(hic_req & ~iso_mode)) && !all_off) |=> (all_off && ch_en == '0 && !rst_out_n));

    // R3
    glob_restart_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(all_off) |-> ((&ch_en) && (&ss_start)));

    for (genvar i = 0; i < N_CH; i++) begin : g_iso
        // R4
        iso_only_chk: assert property (@(posedge clk) disable iff (rst)
            (hic_req[i] && iso_mode[i] && !(|(hic_req & ~iso_mode)) && !all_off)
            |=> (!ch_en[i] && !all_off));
    end

    // R6
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_out_n) |-> $past(|(hic_req & ~irq_mask)));

    // R8
    rst_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_out_n) |-> ($past(&(pok | ~in_seq)) && $past(ms_tick) && !all_off));

    // R9
    flag_src_chk: assert property (@(posedge clk) disable iff (rst)
        (|(oc_flag & ~$past(oc_flag))) |-> $past(|hic_req));

    // R12
    down_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (all_off && oc_clr == '0) |=> (oc_flag == $past(oc_flag)));

endmodule

bind hiccup_recovery_seq hiccup_recovery_seq_chk #(.N_CH(N_CH)) u_chk (.*);

// File: tb/hiccup_recovery_seq_tb.sv
`timescale 1ns/1ps
module hiccup_recovery_seq_tb;
    localparam int N_CH = 4;
    localparam int SS_W = 8;
    localparam int GMS  = 100;
    localparam int DLYW = 8;

    // {req, iso, seq, mask, exp_all_off, exp_en, exp_rst_n, exp_irq_n}
    localparam int NV = 8;
    localparam logic [22:0] VEC [NV] = '{
        23'b0001_0000_0000_0000_1_0000_0_0,   // R2 global
        23'b0010_0010_0010_0000_0_1101_0_0,   // R4 R5 in sequence
        23'b0010_0010_0000_0000_0_1101_1_0,   // R5 not in sequence
        23'b0100_0100_0100_0100_0_1011_0_1,   // R6 masked
        23'b0100_1111_0000_0100_0_1011_1_1,   // R4 R6
        23'b0101_0001_0000_0000_1_0000_0_0,   // R10 mixed -> global
        23'b1001_1001_1000_0001_0_0110_0_0,   // R4 two isolated
        23'b0001_0000_0000_0001_1_0000_0_1    // R10 global, masked
    };

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 ms_tick = 1'b0;
    logic [N_CH-1:0]      hic_req = '0;
    logic [N_CH-1:0]      pok = '1;
    logic [N_CH-1:0]      iso_mode = '0;
    logic [N_CH-1:0]      in_seq = '0;
    logic [N_CH-1:0]      irq_mask = '0;
    logic [N_CH*SS_W-1:0] ss_len = {8'd4, 8'd4, 8'd5, 8'd4};
    logic [DLYW-1:0]      rst_dly = 8'd3;
    logic [N_CH-1:0]      oc_clr = '0;
    logic [N_CH-1:0]      ch_en, ss_start, oc_flag;
    logic                 all_off, rst_out_n, irq_out_n;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    hiccup_recovery_seq #(.N_CH(N_CH), .SS_W(SS_W), .GLOBAL_MS(GMS), .DLY_W(DLYW)) u_dut (
        .clk, .rst, .ms_tick, .hic_req, .pok, .iso_mode, .in_seq, .irq_mask,
        .ss_len, .rst_dly, .oc_clr, .ch_en, .ss_start, .all_off, .rst_out_n,
        .irq_out_n, .oc_flag
    );

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        hic_req = '0;
        ms_tick = 1'b0;
        oc_clr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_req(input logic [N_CH-1:0] v);
        hic_req = v;
        @(negedge clk);
        hic_req = '0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            ms_tick = 1'b1;
            @(negedge clk);
        end
        ms_tick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        do_reset();
        // R1 reset state
        check(ch_en, 4'hF, "R1 ch_en");
        check(all_off, 0, "R1 all_off");
        check(rst_out_n, 1, "R1 rst_out_n");
        check(irq_out_n, 1, "R1 irq_out_n");
        check(oc_flag, 0, "R1 oc_flag");
        check(ss_start, 0, "R1 ss_start");

        // vector table: one request from idle
        for (int v = 0; v < NV; v++) begin
            do_reset();
            iso_mode = VEC[v][18:15];
            in_seq   = VEC[v][14:11];
            irq_mask = VEC[v][10:7];
            pulse_req(VEC[v][22:19]);
            check(all_off,   VEC[v][6],   $sformatf("R2 R10 vec%0d all_off", v));
            check(ch_en,     VEC[v][5:2], $sformatf("R4 vec%0d ch_en", v));
            check(rst_out_n, VEC[v][1],   $sformatf("R5 vec%0d rst_out_n", v));
            check(irq_out_n, VEC[v][0],   $sformatf("R6 vec%0d irq_out_n", v));
        end

        // per-channel off-time, retrigger, reset release, flag clear
        do_reset();
        iso_mode = 4'hF; in_seq = 4'b0010; irq_mask = 4'h0; pok = 4'hF;
        pulse_req(4'b0010);
        pok[1] = 1'b0;
        check(ch_en[1], 0, "R4 ch1 parked");
        check(oc_flag, 4'b0010, "R9 flag set");
        ticks(10);
        pulse_req(4'b0010);       // R11 retrigger
        ticks(14);
        check(ch_en[1], 0, "R11 still parked after 14 ticks");
        ticks(1);
        check(ch_en[1], 1, "R7 re-enabled on tick 15");
        check(ss_start, 4'b0010, "R7 ss_start pulse");
        @(negedge clk);
        check(ss_start, 0, "R7 ss_start one cycle");
        check(rst_out_n, 0, "R8 held while pok low");
        ticks(5);
        check(rst_out_n, 0, "R8 still held, pok low");
        pok[1] = 1'b1;
        ticks(2);
        check(rst_out_n, 0, "R8 held before delay");
        ticks(1);
        check(rst_out_n, 1, "R8 released after delay");
        check(irq_out_n, 0, "R6 irq held");
        check(oc_flag, 4'b0010, "R9 flag sticky");
        oc_clr = 4'b0010;
        @(negedge clk);
        oc_clr = '0;
        check(oc_flag, 0, "R9 flag cleared");
        check(irq_out_n, 1, "R6 irq cleared");

        // global shutdown timing and ignored requests
        do_reset();
        iso_mode = 4'b1110; in_seq = 4'hF; irq_mask = 4'h0; pok = 4'hF;
        pulse_req(4'b0001);
        check(all_off, 1, "R2 all_off");
        ticks(50);
        pulse_req(4'b0010);
        check(oc_flag, 4'b0001, "R12 request ignored while down");
        ticks(49);
        check(all_off, 1, "R3 still down after 99 ticks");
        ticks(1);
        check(all_off, 0, "R3 restart on tick 100");
        check(ch_en, 4'hF, "R3 R12 all enabled");
        check(ss_start, 4'hF, "R3 ss_start all");
        @(negedge clk);
        check(ss_start, 0, "R3 ss_start one cycle");
        ticks(2);
        check(rst_out_n, 0, "R8 held after global restart");
        ticks(1);
        check(rst_out_n, 1, "R8 released after global restart");

        summary();
    end
endmodule